// File: doc/BRIEF.md
# Fetch-Boundary Interrupt Arbiter

This block sits beside the cycle sequencer of a cycle-accurate processor core and decides, at each opcode-fetch boundary, whether the next cycle fetches an opcode or enters a reset, non-maskable or maskable interrupt sequence. The sequencer state is 16 bits wide: the opcode sits in the upper byte and the cycle index inside the instruction (0 to 7) in the lower byte. A state of zero marks the opcode fetch.

Requests are tracked between fetches. The non-maskable line is latched on its rising edge and consumed when taken. The maskable line is the OR of two source lines and is treated as a level. Each of these two requests carries a small saturating age count, so it is taken only after it has been seen for a minimum number of cycles. A reset request wins over everything else. It returns the sequencer to fetch and drops every pending interrupt. When the bus is not available, read cycles are held and no decision is made.

The core feeds its current state, the I flag and the bus status into the block. It takes back the next state, a strobe and the two vector addresses to read (low byte first), and a hold indication that freezes the current read cycle.

Top module: `intArbiter`

## Requirements
- R1: After `rstN` is released, with no request active and the bus available, `vecLoad` is 0, `takeKind` is 0, `holdCycle` is 0 and `nextState` equals `curState`.
- R2: A decision is made only when `curState` is 0. For any other state, `nextState` equals `curState` and `vecLoad` stays 0, even while a request is eligible.
- R3: Priority at the fetch boundary is reset, then non-maskable, then maskable. `takeKind` encodes the outcome as 0 none, 1 maskable, 2 non-maskable and 3 reset.
- R4: A non-maskable request first sampled at clock edge k becomes eligible at the fetch after edge k+2 and no earlier. When taken, `nextState` is 16'h0010, `vecLoAddr` is 16'hFFFA and `vecHiAddr` is 16'hFFFB.
- R5: A non-maskable request is taken once for each rising edge of `nmiIn`. Holding the line high does not raise it again.
- R6: The maskable request is `irqSrcA` OR `irqSrcB`. It needs the same two-edge age as R4 and `iFlag` low. When taken, `nextState` is 16'h0008, `vecLoAddr` is 16'hFFFE and `vecHiAddr` is 16'hFFFF.
- R7: The maskable request is level-sensitive. While masked it stays pending, and it is taken at the first fetch with `iFlag` low, for as long as a source stays high.
- R8: A `resetReq` sampled at an edge is taken at the next fetch. It gives `nextState` 0, `vecLoAddr` 16'hFFFC and `vecHiAddr` 16'hFFFD. It also clears the pending non-maskable request and the record of the line's level, and it restarts the maskable age count.
- R9: With `busAvail` low, no decision is made at fetch and `holdCycle` is 1. Pending requests are kept for the next fetch. At a non-fetch state, `holdCycle` equals `cycleRead` while `busAvail` is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Core clock, one cycle per bus access |
| rstN | input | 1 | Asynchronous active-low hardware reset |
| resetReq | input | 1 | Soft reset request |
| nmiIn | input | 1 | Non-maskable request line, active high |
| irqSrcA | input | 1 | Maskable source line A, active high |
| irqSrcB | input | 1 | Maskable source line B, active high |
| iFlag | input | 1 | Interrupt-disable flag of the core |
| curState | input | 16 | Current sequencer state (opcode:cycle) |
| busAvail | input | 1 | Bus available; low stalls read cycles |
| cycleRead | input | 1 | Current non-fetch cycle is a read |
| nextState | output | 16 | State for the next cycle |
| vecLoad | output | 1 | A reset or interrupt is taken this cycle |
| vecLoAddr | output | 16 | Address of the vector low byte |
| vecHiAddr | output | 16 | Address of the vector high byte |
| takeKind | output | 2 | Outcome code (see R3) |
| holdCycle | output | 1 | Current read cycle must be repeated |

## Verification
A lone non-maskable pulse held high shows the two-edge age gate and that the line fires only once. The same pulse raised during non-fetch states, or during a bus stall, shows that the decision waits for an unstalled fetch and does not lose the request. Each maskable source is driven on its own with the I flag both set and clear, which separates the OR of the sources, the masking and the level behaviour. Requests are then overlapped with a reset request. This shows the priority order, and it shows that reset restarts both the maskable age and the non-maskable edge detector, which makes a held line fire again.

// File: rtl/intArbPkg.sv
package intArbPkg;

  typedef enum logic [1:0] {
    TK_NONE  = 2'd0,
    TK_IRQ   = 2'd1,
    TK_NMI   = 2'd2,
    TK_RESET = 2'd3
  } takeKind_e;

  // Strobes from control to datapath
  typedef struct packed {
    logic takeNmi;
    logic takeIrq;
    logic clearAll;
  } arbStrobe_t;

  localparam logic [15:0] VEC_IRQ_LO   = 16'hFFFE;
  localparam logic [15:0] VEC_NMI_LO   = 16'hFFFA;
  localparam logic [15:0] VEC_RESET_LO = 16'hFFFC;
  localparam logic [15:0] SEQ_FETCH    = 16'h0000;
  localparam logic [15:0] SEQ_NMI      = 16'h0010;
  localparam logic [15:0] SEQ_IRQ      = 16'h0008;

endpackage

// File: rtl/intReqTracker.sv
module intReqTracker #(
  parameter bit EDGE_MODE = 1'b1,
  parameter int MIN_AGE   = 2
) (
  input  logic clk,
  input  logic rstN,
  input  logic line,
  input  logic take,
  input  logic clear,
  output logic pend,
  output logic eligible
);

  localparam int AGE_W = (MIN_AGE < 1) ? 1 : $clog2(MIN_AGE + 1);
  localparam logic [AGE_W-1:0] AGE_MAX = AGE_W'(MIN_AGE);

  logic             seen;
  logic [AGE_W-1:0] age;
  logic             newEdge;
  logic             drop;

  assign newEdge = line & ~seen;
  assign drop    = EDGE_MODE ? take : ~line;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      seen <= 1'b0;
      pend <= 1'b0;
      age  <= '0;
    end else if (clear) begin
      seen <= 1'b0;
      pend <= 1'b0;
      age  <= '0;
    end else begin
      seen <= line;
      if (newEdge) begin
        pend <= 1'b1;
        age  <= '0;
      end else if (drop) begin
        pend <= 1'b0;
        age  <= '0;
      end else if (pend && (age < AGE_MAX)) begin
        age <= age + 1'b1;
      end
    end
  end

  assign eligible = pend && (age >= AGE_MAX) && (EDGE_MODE || line);

  // R4 / R6: an eligible request was already pending one cycle earlier
  a_r4_aged_request: assert property (@(posedge clk) disable iff (!rstN)
    eligible |-> $past(pend));

  generate
    if (EDGE_MODE) begin : g_edgeChk
      // R5: a taken edge request is consumed unless a fresh edge arrives
      a_r5_edge_consumed: assert property (@(posedge clk) disable iff (!rstN)
        (take && !newEdge && !clear) |=> !pend);
    end
  endgenerate

endmodule

// File: rtl/intDatapath.sv
module intDatapath #(
  parameter int MIN_AGE  = 2,
  parameter int IRQ_SRCS = 2
) (
  input  logic                   clk,
  input  logic                   rstN,
  input  logic                   resetReq,
  input  logic                   nmiIn,
  input  logic [IRQ_SRCS-1:0]    irqSrc,
  input  intArbPkg::arbStrobe_t  strobe,
  output logic                   resetPend,
  output logic                   nmiElig,
  output logic                   irqElig
);

  localparam int CHANS = 2;   // channel 0: edge (NMI), channel 1: level (IRQ)

  logic [CHANS-1:0] chanLine;
  logic [CHANS-1:0] chanTake;
  logic [CHANS-1:0] chanPend;
  logic [CHANS-1:0] chanElig;

  assign chanLine[0] = nmiIn;
  assign chanLine[1] = |irqSrc;
  assign chanTake[0] = strobe.takeNmi;
  assign chanTake[1] = strobe.takeIrq;

  generate
    for (genvar g = 0; g < CHANS; g++) begin : g_chan
      intReqTracker #(
        .EDGE_MODE (g == 0),
        .MIN_AGE   (MIN_AGE)
      ) u_trk (
        .clk      (clk),
        .rstN     (rstN),
        .line     (chanLine[g]),
        .take     (chanTake[g]),
        .clear    (strobe.clearAll),
        .pend     (chanPend[g]),
        .eligible (chanElig[g])
      );
    end
  endgenerate

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                resetPend <= 1'b0;
    else if (resetReq)        resetPend <= 1'b1;
    else if (strobe.clearAll) resetPend <= 1'b0;
  end

  assign nmiElig = chanElig[0];
  assign irqElig = chanElig[1];

  // R8: a taken reset leaves nothing pending on the following cycle
  a_r8_reset_clears: assert property (@(posedge clk) disable iff (!rstN)
    (strobe.clearAll && !resetReq) |=> (!resetPend && chanPend == '0));

endmodule

// File: rtl/intControl.sv
module intControl #(
  parameter int STATE_W = 16,
  parameter int ADDR_W  = 16
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic [STATE_W-1:0]    curState,
  input  logic                  busAvail,
  input  logic                  cycleRead,
  input  logic                  iFlag,
  input  logic                  resetPend,
  input  logic                  nmiElig,
  input  logic                  irqElig,
  output logic [STATE_W-1:0]    nextState,
  output logic                  vecLoad,
  output logic [ADDR_W-1:0]     vecLoAddr,
  output logic [ADDR_W-1:0]     vecHiAddr,
  output intArbPkg::takeKind_e  takeKind,
  output logic                  holdCycle,
  output intArbPkg::arbStrobe_t strobe
);
  import intArbPkg::*;

  logic atFetch;
  logic decide;

  assign atFetch = (curState == '0);
  assign decide  = atFetch && busAvail;

  always_comb begin
    takeKind = TK_NONE;
    if (decide) begin
      if (resetPend)                takeKind = TK_RESET;
      else if (nmiElig)             takeKind = TK_NMI;
      else if (irqElig && !iFlag)   takeKind = TK_IRQ;
    end
  end

  always_comb begin
    nextState = curState;
    vecLoAddr = '0;
    unique case (takeKind)
      TK_RESET: begin nextState = STATE_W'(SEQ_FETCH); vecLoAddr = ADDR_W'(VEC_RESET_LO); end
      TK_NMI:   begin nextState = STATE_W'(SEQ_NMI);   vecLoAddr = ADDR_W'(VEC_NMI_LO);   end
      TK_IRQ:   begin nextState = STATE_W'(SEQ_IRQ);   vecLoAddr = ADDR_W'(VEC_IRQ_LO);   end
      default:  ;
    endcase
  end

  assign vecLoad   = (takeKind != TK_NONE);
  assign vecHiAddr = vecLoad ? vecLoAddr + 1'b1 : '0;
  assign holdCycle = !busAvail && (atFetch || cycleRead);

  assign strobe.takeNmi  = (takeKind == TK_NMI);
  assign strobe.takeIrq  = (takeKind == TK_IRQ);
  assign strobe.clearAll = (takeKind == TK_RESET);

  // R2: vectors are loaded only at the fetch boundary
  a_r2_fetch_only: assert property (@(posedge clk) disable iff (!rstN)
    vecLoad |-> (curState == '0));

  // R9: a stalled bus freezes the decision
  a_r9_stall_freezes: assert property (@(posedge clk) disable iff (!rstN)
    !busAvail |-> (!vecLoad && nextState == curState));

  // R6: a set I flag never lets a maskable request through
  a_r6_masked: assert property (@(posedge clk) disable iff (!rstN)
    iFlag |-> (takeKind != TK_IRQ));

  // R3: a pending reset at an open fetch is never overtaken
  a_r3_reset_first: assert property (@(posedge clk) disable iff (!rstN)
    (resetPend && decide) |-> (vecLoAddr == ADDR_W'(VEC_RESET_LO)));

endmodule

// File: rtl/intArbiter.sv
module intArbiter #(
  parameter int STATE_W = 16,
  parameter int ADDR_W  = 16,
  parameter int MIN_AGE = 2
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               resetReq,
  input  logic               nmiIn,
  input  logic               irqSrcA,
  input  logic               irqSrcB,
  input  logic               iFlag,
  input  logic [STATE_W-1:0] curState,
  input  logic               busAvail,
  input  logic               cycleRead,
  output logic [STATE_W-1:0] nextState,
  output logic               vecLoad,
  output logic [ADDR_W-1:0]  vecLoAddr,
  output logic [ADDR_W-1:0]  vecHiAddr,
  output logic [1:0]         takeKind,
  output logic               holdCycle
);
  import intArbPkg::*;

  arbStrobe_t strobe;
  takeKind_e  kind;
  logic       resetPend;
  logic       nmiElig;
  logic       irqElig;

  intDatapath #(
    .MIN_AGE  (MIN_AGE),
    .IRQ_SRCS (2)
  ) u_dp (
    .clk       (clk),
    .rstN      (rstN),
    .resetReq  (resetReq),
    .nmiIn     (nmiIn),
    .irqSrc    ({irqSrcB, irqSrcA}),
    .strobe    (strobe),
    .resetPend (resetPend),
    .nmiElig   (nmiElig),
    .irqElig   (irqElig)
  );

  intControl #(
    .STATE_W (STATE_W),
    .ADDR_W  (ADDR_W)
  ) u_ctl (
    .clk       (clk),
    .rstN      (rstN),
    .curState  (curState),
    .busAvail  (busAvail),
    .cycleRead (cycleRead),
    .iFlag     (iFlag),
    .resetPend (resetPend),
    .nmiElig   (nmiElig),
    .irqElig   (irqElig),
    .nextState (nextState),
    .vecLoad   (vecLoad),
    .vecLoAddr (vecLoAddr),
    .vecHiAddr (vecHiAddr),
    .takeKind  (kind),
    .holdCycle (holdCycle),
    .strobe    (strobe)
  );

  assign takeKind = kind;

endmodule

// File: tb/sim_intArbiter.sv
`timescale 1ns/1ps
module sim_intArbiter;

  logic        clk = 1'b0;
  logic        rstN = 1'b0;
  logic        resetReq = 1'b0, nmiIn = 1'b0, irqSrcA = 1'b0, irqSrcB = 1'b0;
  logic        iFlag = 1'b0, busAvail = 1'b1, cycleRead = 1'b0;
  logic [15:0] curState = 16'h0000;
  logic [15:0] nextState, vecLoAddr, vecHiAddr;
  logic        vecLoad, holdCycle;
  logic [1:0]  takeKind;

  // staged stimulus, applied at the next falling edge
  logic        sRst = 0, sNmi = 0, sIrqA = 0, sIrqB = 0, sI = 0, sBus = 1, sRd = 0;

  int checks = 0;
  int errors = 0;
  bit done = 0;

  typedef struct {
    logic [1:0]  kind;
    logic [15:0] nxt;
    logic        hold;
    string       tag;
  } expItem_t;

  expItem_t expQ[$];

  always #2.5 clk = ~clk;

  intArbiter u0 (
    .clk(clk), .rstN(rstN), .resetReq(resetReq), .nmiIn(nmiIn),
    .irqSrcA(irqSrcA), .irqSrcB(irqSrcB), .iFlag(iFlag), .curState(curState),
    .busAvail(busAvail), .cycleRead(cycleRead), .nextState(nextState),
    .vecLoad(vecLoad), .vecLoAddr(vecLoAddr), .vecHiAddr(vecHiAddr),
    .takeKind(takeKind), .holdCycle(holdCycle)
  );

  function automatic logic [15:0] vecFor(input logic [1:0] k);
    case (k)
      2'd1: return 16'hFFFE;
      2'd2: return 16'hFFFA;
      2'd3: return 16'hFFFC;
      default: return 16'h0000;
    endcase
  endfunction

  // driver: apply staged inputs for one cycle and queue the expected result
  task automatic cyc(input logic [15:0] st, input logic [1:0] k,
                     input logic [15:0] nxt, input logic hold, input string tag);
    expItem_t e;
    @(negedge clk);
    resetReq = sRst; nmiIn = sNmi; irqSrcA = sIrqA; irqSrcB = sIrqB;
    iFlag = sI; busAvail = sBus; cycleRead = sRd; curState = st;
    e.kind = k; e.nxt = nxt; e.hold = hold; e.tag = tag;
    expQ.push_back(e);
  endtask

  task automatic idle(input string tag);
    cyc(16'h0000, 2'd0, 16'h0000, 1'b0, tag);
  endtask

  // monitor: compare away from the active edge
  initial begin
    forever begin
      @(negedge clk);
      #1.5;
      if (expQ.size() > 0) begin
        expItem_t e;
        logic ok;
        e = expQ.pop_front();
        checks++;
        ok = (takeKind == e.kind) && (nextState == e.nxt) && (holdCycle == e.hold) &&
             (vecLoad == (e.kind != 2'd0));
        if (e.kind != 2'd0)
          ok = ok && (vecLoAddr == vecFor(e.kind)) && (vecHiAddr == vecFor(e.kind) + 16'd1);
        if (!ok) begin
          errors++;
          $display("FAIL %s: kind %0d exp %0d, next %h exp %h, hold %0d exp %0d, vec %h/%h exp %h",
                   e.tag, takeKind, e.kind, nextState, e.nxt, holdCycle, e.hold,
                   vecLoAddr, vecHiAddr, vecFor(e.kind));
        end
      end
    end
  end

  initial begin
    #(5.0 * 50000);
    if (!done) begin
      errors++;
      $display("FAIL watchdog: run did not complete");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;

    // R1 reset state
    idle("R1 idle after reset");
    cyc(16'h1234, 2'd0, 16'h1234, 1'b0, "R1 R2 pass-through");

    // R4 / R5: lone NMI held high
    sNmi = 1; idle("R4 age 0");
    idle("R4 age 1");
    idle("R4 age 2 not yet");
    cyc(16'h0000, 2'd2, 16'h0010, 1'b0, "R4 nmi taken");
    idle("R5 held line no retrigger");
    idle("R5 held line no retrigger 2");
    sNmi = 0; idle("R5 line released");
    idle("R5 quiet");

    // R2: NMI ripens during non-fetch states
    sNmi = 1; cyc(16'h2003, 2'd0, 16'h2003, 1'b0, "R2 nonfetch 0");
    cyc(16'h2004, 2'd0, 16'h2004, 1'b0, "R2 nonfetch 1");
    cyc(16'h2005, 2'd0, 16'h2005, 1'b0, "R2 nonfetch 2");
    cyc(16'h2006, 2'd0, 16'h2006, 1'b0, "R2 eligible but not fetch");
    cyc(16'h0000, 2'd2, 16'h0010, 1'b0, "R2 taken at fetch");
    sNmi = 0; idle("R2 released");

    // R9: bus stall at fetch keeps request
    sNmi = 1; idle("R9 raise");
    idle("R9 age 1");
    idle("R9 age 2");
    sBus = 0; cyc(16'h0000, 2'd0, 16'h0000, 1'b1, "R9 stalled fetch");
    cyc(16'h0000, 2'd0, 16'h0000, 1'b1, "R9 stalled fetch 2");
    sBus = 1; cyc(16'h0000, 2'd2, 16'h0010, 1'b0, "R9 taken after stall");
    sNmi = 0; sBus = 0; sRd = 1;
    cyc(16'h0105, 2'd0, 16'h0105, 1'b1, "R9 nonfetch read held");
    sRd = 0; cyc(16'h0105, 2'd0, 16'h0105, 1'b0, "R9 nonfetch write not held");
    sBus = 1; idle("R9 bus back");

    // R6: maskable via source A
    sIrqA = 1; idle("R6 age 0");
    idle("R6 age 1");
    idle("R6 age 2 not yet");
    cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R6 irq A taken");
    cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R7 level still taken");
    sIrqA = 0; idle("R7 line low not taken");

    // R7: maskable via source B while masked
    sI = 1; sIrqB = 1; idle("R7 masked 0");
    idle("R7 masked 1");
    idle("R7 masked 2");
    idle("R7 masked aged");
    sI = 0; cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R7 taken when unmasked");
    sIrqB = 0; idle("R7 released");

    // R3: priority NMI over IRQ, reset over IRQ; R8 restarts IRQ age
    sNmi = 1; sIrqA = 1; idle("R3 raise both");
    idle("R3 age 1");
    idle("R3 age 2");
    cyc(16'h0000, 2'd2, 16'h0010, 1'b0, "R3 nmi beats irq");
    cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R3 irq after nmi");
    sNmi = 0; sRst = 1; cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R3 reset not yet pending");
    sRst = 0; cyc(16'h0000, 2'd3, 16'h0000, 1'b0, "R3 R8 reset beats irq");
    idle("R8 irq age restart 0");
    idle("R8 irq age restart 1");
    idle("R8 irq age restart 2");
    cyc(16'h0000, 2'd1, 16'h0008, 1'b0, "R8 irq after restart");
    sIrqA = 0; idle("R8 irq released");

    // R8: reset clears NMI pending and line record
    sNmi = 1; idle("R8 nmi raise");
    sRst = 1; idle("R8 reset request");
    sRst = 0; cyc(16'h0000, 2'd3, 16'h0000, 1'b0, "R8 reset beats nmi");
    idle("R8 nmi cleared");
    idle("R8 nmi re-seen");
    idle("R8 nmi age 1");
    cyc(16'h0000, 2'd2, 16'h0010, 1'b0, "R8 held nmi fires again");
    idle("R5 no retrigger after");
    sNmi = 0; idle("final idle");

    @(negedge clk);
    #3;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule